// File: doc/BRIEF.md
# Imbalanced Way-Partition Controller for a Shared Cache

This block decides how the ways of a shared set-associative last-level cache are split among a fixed number of symmetric threads. For every cache access it is told which thread made it, whether it hit, and the recency stack position of the hit within its set. It counts these positions in a per-thread histogram. From the running sums of that histogram it judges which threads can give up ways cheaply. It also judges whether one chosen thread would gain a lot from receiving them.

At the end of each epoch of accesses it publishes one way mask per thread to the replacement logic. In a partitioned decision, one preferred thread receives every way the other threads give up, and the others keep a reduced share. The preferred thread moves round-robin from epoch to epoch. When no donation pays off, or when the shared fallback is requested, every mask is all-ones and the cache behaves as a plain shared LRU cache.

Top module: `llc_way_partitioner`

## Requirements
- R1: After reset every way mask is all-ones, `sharedMode` is 1 and `preferred` is 0.
- R2: An access with `accHit`=1 and `accPos` = p in 1..WAYS adds one to bucket p of thread `accThread`. A bucket saturates at 2^CNT_W-1. Misses and hits whose position lies outside 1..WAYS change no bucket.
- R3: An epoch closes with the 2^EPOCH_LOG-th accepted access. Masks and `sharedMode` change only on the second clock edge after the edge that accepts that access. The decision uses histograms that include that access.
- R4: Let Q = WAYS/THREADS. Each non-preferred thread donates the largest d in 0..Q-1 for which its buckets Q-d+1..Q sum to strictly less than `lossThresh`.
- R5: Let D be the total number of donated ways. The decision is partitioned only when D > 0 and some bucket p of the preferred thread, with Q < p <= Q+D, is at least `kneeThresh`. Otherwise the decision is shared.
- R6: In a partitioned decision, the preferred thread owns Q+D ways and each donor owns Q-d ways. Each thread's ways are contiguous, and thread 0 starts at way 0 with the next thread above it. Mask of thread t is bits [t*WAYS +: WAYS] of `wayMasks`. Masks are disjoint, together cover all ways, and none is empty.
- R7: In a shared decision every mask is all-ones and `sharedMode` is 1.
- R8: When `forceShared` is 1 in the cycle in which the decision is taken, the decision is shared.
- R9: `preferred` advances by one at each decision, wrapping from THREADS-1 to 0. It changes at no other time.
- R10: At each decision every bucket is halved (rounded down) before any count from that cycle is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | One cache access this cycle |
| accThread | input | TW | Thread that made the access |
| accHit | input | 1 | Access hit in the cache |
| accPos | input | PW | Recency stack position of the hit, 1 = most recent |
| forceShared | input | 1 | Request the shared fallback at the next decision |
| kneeThresh | input | CNT_W | Minimum single-bucket count that counts as a knee |
| lossThresh | input | CNT_W | Donor loss must stay below this |
| wayMasks | output | THREADS*WAYS | Per-thread way masks for the replacement logic |
| sharedMode | output | 1 | Current decision is the shared fallback |
| preferred | output | TW | Thread favoured at the next decision |

## Verification
The decision strobe is registered one edge after the epoch's last access is accepted, and the mask register loads on the following edge. The bench therefore samples twice on the falling edges after that last access. At the first sample the previous masks must still be present, and at the second the new masks, `sharedMode` and the advanced `preferred` must all be visible. Histogram effects such as saturation, halving and ignored positions are not visible until the end of an epoch, so each one is observed through the mask pattern that the next decision produces. Each epoch of the test is built so that the two possible outcomes give different masks.

// File: rtl/llc_wp_pkg.sv
package llc_wp_pkg;
  // Strobes from the epoch controller to the histogram/allocation datapath
  typedef struct packed {
    logic countEn;  // an access is presented this cycle
    logic decide;   // allocate, load masks and halve histograms this cycle
  } wpStrobe_t;
endpackage

// File: rtl/llc_wp_control.sv
module llc_wp_control
  import llc_wp_pkg::*;
#(
  parameter int THREADS   = 4,
  parameter int EPOCH_LOG = 16,
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          accValid,
  output wpStrobe_t     strobe,
  output logic [TW-1:0] preferred
);
  localparam logic [TW-1:0] LAST_THREAD = TW'(THREADS - 1);

  logic [EPOCH_LOG-1:0] accCnt;
  logic                 decideQ;
  logic                 epochLast;

  assign epochLast = accValid && (accCnt == '1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accCnt    <= '0;
      decideQ   <= 1'b0;
      preferred <= '0;
    end else begin
      if (accValid) accCnt <= accCnt + 1'b1;
      decideQ <= epochLast;
      if (decideQ) preferred <= (preferred == LAST_THREAD) ? '0 : preferred + 1'b1;
    end
  end

  assign strobe.countEn = accValid;
  assign strobe.decide  = decideQ;
endmodule

// File: rtl/llc_wp_datapath.sv
module llc_wp_datapath
  import llc_wp_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int WAYS    = 16,
  parameter int CNT_W   = 16,
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int PW = $clog2(WAYS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  wpStrobe_t               strobe,
  input  logic [TW-1:0]           accThread,
  input  logic                    accHit,
  input  logic [PW-1:0]           accPos,
  input  logic                    forceShared,
  input  logic [CNT_W-1:0]        kneeThresh,
  input  logic [CNT_W-1:0]        lossThresh,
  input  logic [TW-1:0]           preferred,
  output logic [THREADS*WAYS-1:0] wayMasks,
  output logic                    sharedMode
);
  localparam int QUOTA = WAYS / THREADS;

  logic [THREADS*WAYS*CNT_W-1:0] histFlat;

  // One saturating counter per thread and stack position
  for (genvar t = 0; t < THREADS; t++) begin : gThread
    for (genvar b = 0; b < WAYS; b++) begin : gBucket
      logic [CNT_W-1:0] cnt;
      logic [CNT_W-1:0] base;
      logic             hitHere;

      assign hitHere = strobe.countEn && accHit &&
                       (accThread == TW'(t)) && (accPos == PW'(b + 1));
      assign base    = strobe.decide ? (cnt >> 1) : cnt;

      always_ff @(posedge clk) begin
        if (!rstN) cnt <= '0;
        else if (strobe.decide || hitHere)
          cnt <= (hitHere && (base != '1)) ? base + 1'b1 : base;
      end

      assign histFlat[(t*WAYS + b)*CNT_W +: CNT_W] = cnt;
    end
  end

  // Allocation decision
  int                    donate [THREADS];
  int                    cum;
  int                    total;
  int                    off;
  int                    share;
  logic                  kneeHit;
  logic                  partition;
  logic [THREADS*WAYS-1:0] maskNext;

  always_comb begin
    total = 0;
    cum   = 0;
    for (int t = 0; t < THREADS; t++) begin
      donate[t] = 0;
      if (t != int'(preferred)) begin
        cum = 0;
        for (int d = 1; d < QUOTA; d++) begin
          cum = cum + int'(histFlat[(t*WAYS + (QUOTA - d))*CNT_W +: CNT_W]);
          if ((cum < int'(lossThresh)) && (donate[t] == d - 1)) donate[t] = d;
        end
      end
      total = total + donate[t];
    end

    kneeHit = 1'b0;
    for (int p = QUOTA + 1; p <= WAYS; p++) begin
      if ((p <= QUOTA + total) &&
          (int'(histFlat[(int'(preferred)*WAYS + p - 1)*CNT_W +: CNT_W]) >= int'(kneeThresh)))
        kneeHit = 1'b1;
    end

    partition = (total != 0) && kneeHit && !forceShared;

    off      = 0;
    share    = 0;
    maskNext = '0;
    for (int t = 0; t < THREADS; t++) begin
      share = (t == int'(preferred)) ? (QUOTA + total) : (QUOTA - donate[t]);
      for (int w = 0; w < WAYS; w++)
        if ((w >= off) && (w < off + share)) maskNext[t*WAYS + w] = 1'b1;
      off = off + share;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wayMasks   <= '1;
      sharedMode <= 1'b1;
    end else if (strobe.decide) begin
      wayMasks   <= partition ? maskNext : '1;
      sharedMode <= !partition;
    end
  end
endmodule

// File: rtl/llc_way_partitioner.sv
module llc_way_partitioner
  import llc_wp_pkg::*;
#(
  parameter int THREADS   = 4,
  parameter int WAYS      = 16,
  parameter int CNT_W     = 16,
  parameter int EPOCH_LOG = 16,
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int PW = $clog2(WAYS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    accValid,
  input  logic [TW-1:0]           accThread,
  input  logic                    accHit,
  input  logic [PW-1:0]           accPos,
  input  logic                    forceShared,
  input  logic [CNT_W-1:0]        kneeThresh,
  input  logic [CNT_W-1:0]        lossThresh,
  output logic [THREADS*WAYS-1:0] wayMasks,
  output logic                    sharedMode,
  output logic [TW-1:0]           preferred
);
  wpStrobe_t strobe;

  llc_wp_control #(.THREADS(THREADS), .EPOCH_LOG(EPOCH_LOG)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .accValid (accValid),
    .strobe   (strobe),
    .preferred(preferred)
  );

  llc_wp_datapath #(.THREADS(THREADS), .WAYS(WAYS), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .accThread  (accThread),
    .accHit     (accHit),
    .accPos     (accPos),
    .forceShared(forceShared),
    .kneeThresh (kneeThresh),
    .lossThresh (lossThresh),
    .preferred  (preferred),
    .wayMasks   (wayMasks),
    .sharedMode (sharedMode)
  );
endmodule

// File: rtl/llc_wp_checker.sv
module llc_wp_checker #(
  parameter int THREADS   = 4,
  parameter int WAYS      = 16,
  parameter int EPOCH_LOG = 16,
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    accValid,
  input logic                    forceShared,
  input logic [THREADS*WAYS-1:0] wayMasks,
  input logic                    sharedMode,
  input logic [TW-1:0]           preferred
);
  localparam logic [TW-1:0] LAST_THREAD = TW'(THREADS - 1);

  logic [EPOCH_LOG-1:0] obsCnt;
  logic                 lastAcc;
  logic [WAYS-1:0]      unionM;
  logic [WAYS-1:0]      overlap;
  logic                 allNonZero;

  always_ff @(posedge clk) begin
    if (!rstN) obsCnt <= '0;
    else if (accValid) obsCnt <= obsCnt + 1'b1;
  end
  assign lastAcc = accValid && (obsCnt == '1);

  always_comb begin
    unionM     = '0;
    overlap    = '0;
    allNonZero = 1'b1;
    for (int t = 0; t < THREADS; t++) begin
      overlap = overlap | (unionM & wayMasks[t*WAYS +: WAYS]);
      unionM  = unionM | wayMasks[t*WAYS +: WAYS];
      if (wayMasks[t*WAYS +: WAYS] == '0) allNonZero = 1'b0;
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(lastAcc, 2) |-> ($stable(wayMasks) && $stable(sharedMode))); // R3
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !sharedMode |-> (overlap == '0)); // R6
  AST_FULL_COVER: assert property (@(posedge clk) disable iff (!rstN)
    !sharedMode |-> (&unionM)); // R6
  AST_MIN_ONE_WAY: assert property (@(posedge clk) disable iff (!rstN)
    !sharedMode |-> allNonZero); // R6
  AST_SHARED_ONES: assert property (@(posedge clk) disable iff (!rstN)
    sharedMode |-> (&wayMasks)); // R7
  AST_FORCE_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lastAcc, 2) && $past(forceShared)) |-> sharedMode); // R8
  AST_ROTATE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(lastAcc, 2) |-> (preferred == (($past(preferred) == LAST_THREAD) ? '0 : $past(preferred) + 1'b1))); // R9
  AST_ROTATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(lastAcc, 2) |-> $stable(preferred)); // R9
endmodule

bind llc_way_partitioner llc_wp_checker #(
  .THREADS(THREADS), .WAYS(WAYS), .EPOCH_LOG(EPOCH_LOG)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .accValid   (accValid),
  .forceShared(forceShared),
  .wayMasks   (wayMasks),
  .sharedMode (sharedMode),
  .preferred  (preferred)
);

// File: tb/llc_way_partitioner_tb.sv
module llc_way_partitioner_tb;
  localparam int THREADS = 4;
  localparam int WAYS    = 8;
  localparam int CNT_W   = 4;
  localparam int ELOG    = 5;
  localparam int EPOCH   = 1 << ELOG;
  localparam logic [31:0] ALL1 = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [1:0]  accThread = '0;
  logic        accHit = 1'b0;
  logic [3:0]  accPos = '0;
  logic        forceShared = 1'b0;
  logic [3:0]  kneeThresh = '0;
  logic [3:0]  lossThresh = '0;
  logic [31:0] wayMasks;
  logic        sharedMode;
  logic [1:0]  preferred;

  int nChecks = 0;
  int nErrors = 0;

  always #5 clk = ~clk;

  llc_way_partitioner #(.THREADS(THREADS), .WAYS(WAYS), .CNT_W(CNT_W), .EPOCH_LOG(ELOG)) u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accThread(accThread), .accHit(accHit),
    .accPos(accPos), .forceShared(forceShared), .kneeThresh(kneeThresh), .lossThresh(lossThresh),
    .wayMasks(wayMasks), .sharedMode(sharedMode), .preferred(preferred)
  );

  typedef struct packed {
    logic [1:0]  tA; logic [3:0] pA; logic hA; logic [5:0] nA;
    logic [1:0]  tB; logic [3:0] pB; logic hB; logic [5:0] nB;
    logic [3:0]  knee; logic [3:0] loss; logic frc;
    logic        expShared; logic [31:0] expMask;
  } vec_t;

  // Each vector is one epoch run from reset, preferred thread 0, Q = 2
  localparam vec_t VECS [11] = '{
    '{2'd0,4'd0,1'b0,6'd0,  2'd0,4'd0,1'b0,6'd0,  4'd1,4'd1,1'b0, 1'b1, ALL1},          // R5 no knee at all
    '{2'd0,4'd3,1'b1,6'd6,  2'd0,4'd0,1'b0,6'd0,  4'd4,4'd1,1'b0, 1'b0, 32'h8040201F},  // R5 R6 three donors
    '{2'd0,4'd4,1'b1,6'd6,  2'd1,4'd2,1'b1,6'd3,  4'd4,4'd2,1'b0, 1'b0, 32'h8040300F},  // R4 thread 1 keeps ways
    '{2'd0,4'd3,1'b1,6'd6,  2'd0,4'd0,1'b0,6'd0,  4'd4,4'd1,1'b1, 1'b1, ALL1},          // R8 forced fallback
    '{2'd0,4'd6,1'b1,6'd10, 2'd0,4'd0,1'b0,6'd0,  4'd4,4'd1,1'b0, 1'b1, ALL1},          // R5 knee out of reach
    '{2'd0,4'd3,1'b1,6'd6,  2'd0,4'd0,1'b0,6'd0,  4'd4,4'd0,1'b0, 1'b1, ALL1},          // R4 zero loss budget
    '{2'd0,4'd3,1'b1,6'd3,  2'd0,4'd0,1'b0,6'd0,  4'd4,4'd1,1'b0, 1'b1, ALL1},          // R5 just below knee
    '{2'd0,4'd3,1'b1,6'd4,  2'd0,4'd0,1'b0,6'd0,  4'd4,4'd1,1'b0, 1'b0, 32'h8040201F},  // R5 knee equal
    '{2'd0,4'd3,1'b0,6'd6,  2'd0,4'd12,1'b1,6'd6, 4'd4,4'd1,1'b0, 1'b1, ALL1},          // R2 ignored accesses
    '{2'd0,4'd3,1'b1,6'd20, 2'd0,4'd0,1'b0,6'd0,  4'd15,4'd1,1'b0, 1'b0, 32'h8040201F}, // R2 saturation at 15
    '{2'd0,4'd3,1'b1,6'd6,  2'd1,4'd2,1'b1,6'd1,  4'd4,4'd1,1'b0, 1'b0, 32'h8040300F}   // R4 loss equal threshold
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; accValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic issue(input int n, input logic [1:0] t, input logic h, input logic [3:0] p);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      accValid = 1'b1; accThread = t; accHit = h; accPos = p;
    end
  endtask

  // One full epoch; checks the old masks one sample after the last access
  // and the new decision one sample later (R3)
  task automatic runEpoch(input vec_t v, input logic [31:0] prevMask, input string tag);
    int fill;
    fill = EPOCH - int'(v.nA) - int'(v.nB);
    kneeThresh = v.knee; lossThresh = v.loss; forceShared = v.frc;
    issue(int'(v.nA), v.tA, v.hA, v.pA);
    issue(int'(v.nB), v.tB, v.hB, v.pB);
    issue(fill, 2'd0, 1'b0, 4'd0);
    @(negedge clk);
    accValid = 1'b0;
    check("R3", {tag, " masks held until update"}, wayMasks, prevMask);
    @(negedge clk);
    check("R6", {tag, " masks"}, wayMasks, v.expMask);
    check("R7", {tag, " shared flag"}, 32'(sharedMode), 32'(v.expShared));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    // R1 reset state
    doReset();
    @(negedge clk);
    check("R1", "reset masks", wayMasks, ALL1);
    check("R1", "reset shared", 32'(sharedMode), 32'd1);
    check("R1", "reset preferred", 32'(preferred), 32'd0);

    // Vector table: R2 R4 R5 R6 R7 R8
    for (int k = 0; k < 11; k++) begin
      doReset();
      runEpoch(VECS[k], ALL1, $sformatf("vec%0d", k));
      check("R9", $sformatf("vec%0d preferred", k), 32'(preferred), 32'd1);
    end

    // R10 halving: 8 hits become 4, which meets a knee of 4
    doReset();
    runEpoch('{2'd1,4'd3,1'b1,6'd8, 2'd0,4'd3,1'b1,6'd6, 4'd4,4'd1,1'b0, 1'b0, 32'h8040201F}, ALL1, "halvA");
    runEpoch('{2'd0,4'd0,1'b0,6'd0, 2'd0,4'd0,1'b0,6'd0, 4'd4,4'd1,1'b0, 1'b0, 32'h80403E01}, 32'h8040201F, "R10 halved kept");
    check("R9", "preferred after two decisions", 32'(preferred), 32'd2);

    // R10 halving: 4 stays below a knee of 5
    doReset();
    runEpoch('{2'd1,4'd3,1'b1,6'd8, 2'd0,4'd3,1'b1,6'd6, 4'd4,4'd1,1'b0, 1'b0, 32'h8040201F}, ALL1, "halvB");
    runEpoch('{2'd0,4'd0,1'b0,6'd0, 2'd0,4'd0,1'b0,6'd0, 4'd5,4'd1,1'b0, 1'b1, ALL1}, 32'h8040201F, "R10 halved below");

    // R9 rotation wraps after THREADS decisions
    doReset();
    for (int e = 1; e <= THREADS; e++) begin
      runEpoch('{2'd0,4'd0,1'b0,6'd0, 2'd0,4'd0,1'b0,6'd0, 4'd1,4'd1,1'b0, 1'b1, ALL1}, ALL1, "rot");
      check("R9", $sformatf("preferred after %0d decisions", e), 32'(preferred), 32'(e % THREADS));
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule